// File: doc/BRIEF.md
# Dual-Role SPI Controller

This block is the serial peripheral of a small 8-bit controller. The processor reaches it through three byte-wide registers on a simple synchronous write / combinational read bus: a control register, a status register and one data register. The data register is used for both directions. A byte written to it goes out on the serial line, and once the transfer is over it holds the byte that came in. The block drives four SPI pins. Each output pin has its own output-enable, so a pad ring can make the pin an input or release it.

The control bits and the level on the slave-select input together pick the role. The block can be off, a master, a selected slave or a deselected slave. A master that sees slave-select pulled low, while the select input is not being ignored, gives up the bus. It clears its own master bit and reports this through the completion flag. A completion flag and a write-collision flag are cleared by writing 1 to them. An interrupt request is the completion flag gated by a local enable and a global enable input. The pin inputs are assumed to be synchronous to `clk` already.

Top module: `spi_dual_role`

## Requirements
- R1: Register addresses are control 0, status 1 and data 2. Control bits are: bit0 enable, bit1 master, bit2 ignore-select, bit3 clock polarity, bit4 clock phase, bits6:5 rate code, bit7 interrupt enable. Status bit7 is the completion flag and bit6 is the collision flag. After reset, all three registers read 0, every output-enable is 0 and `irq` is 0.
- R2: In the master role, writing the data register when idle starts an 8-bit full-duplex exchange, MSB first, with 16 clock edges. At the end, the data register holds the byte sampled from `miso_i` and the completion flag is 1.
- R3: Writing 1 to status bit7 or bit6 clears that flag. Writing 0 to a bit leaves that flag unchanged.
- R4: Writing the data register while a transfer is in progress sets the collision flag. The write is discarded: the byte in flight and the byte received are not changed.
- R5: If enable=1, master=1, ignore-select=0 and `ss_n_i`=0, then on the next cycle the master bit reads 0 and the completion flag is 1. Any master transfer in progress is stopped and `sclk_oe` drops.
- R6: The master clock half-period is 2, 8, 32 or 64 `clk` cycles for rate codes 0, 1, 2 and 3. This is a division of 4, 16, 64 or 128.
- R7: With enable=0, all three output-enables are 0, no transfer starts, and select-low does not change the master bit.
- R8: A slave is selected when ignore-select is 1 or `ss_n_i` is 0. A selected slave enables `miso_o` and exchanges 8 bits, MSB first, on the edges of `sclk_i`. It then holds the received byte and sets the completion flag.
- R9: A deselected slave (ignore-select=0, `ss_n_i`=1, master=0) keeps `miso_oe` at 0 and ignores `sclk_i`. Its data register and flags are unchanged.
- R10: `irq` is 1 exactly when the completion flag, the interrupt-enable bit and `gie` are all 1.
- R11: When idle, `sclk_o` equals the polarity bit. With phase=0, data is sampled on the edge that leaves the idle level. With phase=1, data is sampled on the edge that returns to it.
- R12: In the master role, `sclk_oe`=1, `mosi_oe`=1 and `miso_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sclk_i | input | 1 | Serial clock in (slave) |
| sclk_o | output | 1 | Serial clock out (master) |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out line in (slave) |
| mosi_o | output | 1 | Master-out line out |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in line in (master) |
| miso_o | output | 1 | Master-in line out (slave) |
| miso_oe | output | 1 | Master-in output enable |
| ss_n_i | input | 1 | Slave select, active low |

## Verification
The bench builds the block with its defaults: an 8-bit data width and a longest half-period of 64 cycles. At these values, all four rate codes and all four polarity/phase pairs fit in short runs, since the slowest byte takes about a thousand cycles. The same settings cover a master abort part way through a byte and a collision during a slow transfer.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;

  typedef enum logic [1:0] {
    ROLE_OFF    = 2'd0,
    ROLE_MASTER = 2'd1,
    ROLE_SEL    = 2'd2,
    ROLE_DESEL  = 2'd3
  } role_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam int B_EN    = 0;
  localparam int B_MSTR  = 1;
  localparam int B_SSIGN = 2;
  localparam int B_CPOL  = 3;
  localparam int B_CPHA  = 4;
  localparam int B_RATE  = 5;
  localparam int B_IE    = 7;
  localparam int B_DONE  = 7;
  localparam int B_COLL  = 6;

  // serial clock half-period in system cycles for each rate code
  function automatic int unsigned half_cycles(input logic [1:0] code);
    case (code)
      2'd0:    return 2;
      2'd1:    return 8;
      2'd2:    return 32;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/spi_dr_role.sv
module spi_dr_role
  import spi_dr_pkg::*;
(
  input  logic  en,
  input  logic  mstr,
  input  logic  ss_ign,
  input  logic  ss_n,
  output role_e role,
  output logic  fault,
  output logic  sclk_oe,
  output logic  mosi_oe,
  output logic  miso_oe
);

  always_comb begin
    fault = en && mstr && !ss_ign && !ss_n;
    if (!en)                     role = ROLE_OFF;
    else if (mstr && (ss_ign || ss_n)) role = ROLE_MASTER;
    else if (ss_ign || !ss_n)    role = ROLE_SEL;
    else                         role = ROLE_DESEL;
  end

  always_comb begin
    sclk_oe = (role == ROLE_MASTER);
    mosi_oe = (role == ROLE_MASTER);
    miso_oe = (role == ROLE_SEL);
  end

endmodule

// File: rtl/spi_dr_clkgen.sv
module spi_dr_clkgen
  import spi_dr_pkg::*;
#(
  parameter int DW       = 8,
  parameter int MAX_HALF = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic [1:0] rate,
  output logic       busy,
  output logic       phase,
  output logic       lead,
  output logic       trail,
  output logic       finish
);

  localparam int HC_W = $clog2(MAX_HALF);
  localparam int TG_W = $clog2(2 * DW);
  localparam logic [TG_W-1:0] LAST_TG = TG_W'(2 * DW - 1);

  logic [HC_W-1:0] hc_q;
  logic [TG_W-1:0] tg_q;
  logic            busy_q, phase_q;
  logic [HC_W-1:0] lim;
  logic            tick;

  always_comb begin
    lim    = HC_W'(half_cycles(rate) - 1);
    tick   = busy_q && !abort && (hc_q >= lim);
    lead   = tick && !phase_q;
    trail  = tick && phase_q;
    finish = tick && (tg_q == LAST_TG);
    busy   = busy_q;
    phase  = phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q <= '0; tg_q <= '0; busy_q <= 1'b0; phase_q <= 1'b0;
    end else if (abort) begin
      hc_q <= '0; tg_q <= '0; busy_q <= 1'b0; phase_q <= 1'b0;
    end else if (start) begin
      hc_q <= '0; tg_q <= '0; busy_q <= 1'b1; phase_q <= 1'b0;
    end else if (busy_q) begin
      if (tick) begin
        hc_q    <= '0;
        phase_q <= !phase_q;
        tg_q    <= tg_q + 1'b1;
        if (tg_q == LAST_TG) busy_q <= 1'b0;
      end else begin
        hc_q <= hc_q + 1'b1;
      end
    end
  end

  assert_idle_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !phase_q);
  assert_finish_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy_q);
  assert_clock_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick && !abort) |=> (phase_q == $past(phase_q)));

endmodule

// File: rtl/spi_dr_shifter.sv
module spi_dr_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          lead,
  input  logic          trail,
  input  logic          cpha,
  input  logic          din,
  output logic [DW-1:0] sh,
  output logic          mid,
  output logic          byte_done
);

  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] LAST = BW'(DW - 1);

  logic [DW-1:0] sh_q;
  logic [BW-1:0] bits_q;
  logic          rx_q, pend_q;
  logic          samp, shft;

  always_comb begin
    samp      = !clear && (cpha ? trail : lead);
    shft      = !clear && (cpha ? lead : trail);
    byte_done = samp && (bits_q == LAST);
    mid       = pend_q || (bits_q != '0);
    sh        = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; bits_q <= '0; rx_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      if (load) sh_q <= load_val;
      if (clear) begin
        bits_q <= '0;
        pend_q <= 1'b0;
      end else if (samp) begin
        if (bits_q == LAST) begin
          sh_q   <= {sh_q[DW-2:0], din};
          bits_q <= '0;
          pend_q <= 1'b0;
        end else begin
          rx_q   <= din;
          pend_q <= 1'b1;
          bits_q <= bits_q + 1'b1;
        end
      end else if (shft && pend_q) begin
        sh_q   <= {sh_q[DW-2:0], rx_q};
        pend_q <= 1'b0;
      end
    end
  end

  assert_byte_rewinds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (bits_q == '0 && !pend_q));
  assert_sample_pends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (samp && bits_q != LAST) |=> pend_q);

endmodule

// File: rtl/spi_dual_role.sv
module spi_dual_role
  import spi_dr_pkg::*;
#(
  parameter int DW       = 8,
  parameter int MAX_HALF = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          gie,
  output logic          irq,
  input  logic          sclk_i,
  output logic          sclk_o,
  output logic          sclk_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          ss_n_i
);

  logic [7:0] ctrl_q;
  logic       done_q, coll_q, sclk_prev_q;

  role_e      role;
  logic       fault;
  logic       cg_busy, cg_phase, cg_lead, cg_trail, cg_finish, cg_start, cg_abort;
  logic [DW-1:0] sh;
  logic       sh_mid, sh_done, sh_clear, sh_lead, sh_trail, sh_load, sh_din;
  logic       s_chg, s_lead, s_trail;
  logic       wr_ctrl, wr_stat, wr_data, busy;
  logic       done_set, done_clr, coll_set, coll_clr;
  logic       cpol, cpha;
  logic [1:0] rate;

  assign cpol = ctrl_q[B_CPOL];
  assign cpha = ctrl_q[B_CPHA];
  assign rate = ctrl_q[B_RATE +: 2];

  spi_dr_role u_role (
    .en      (ctrl_q[B_EN]),
    .mstr    (ctrl_q[B_MSTR]),
    .ss_ign  (ctrl_q[B_SSIGN]),
    .ss_n    (ss_n_i),
    .role    (role),
    .fault   (fault),
    .sclk_oe (sclk_oe),
    .mosi_oe (mosi_oe),
    .miso_oe (miso_oe)
  );

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    wr_stat  = bus_wr && (bus_addr == A_STAT);
    wr_data  = bus_wr && (bus_addr == A_DATA);
    busy     = cg_busy || sh_mid;
    sh_load  = wr_data && !busy;
    cg_start = sh_load && (role == ROLE_MASTER);
    cg_abort = (role != ROLE_MASTER);
    sh_clear = (role == ROLE_OFF) || (role == ROLE_DESEL) || fault ||
               (cg_busy && role != ROLE_MASTER) ||
               (role == ROLE_MASTER && !cg_busy);
    s_chg    = (role == ROLE_SEL) && (sclk_i != sclk_prev_q);
    s_lead   = s_chg && (sclk_i != cpol);
    s_trail  = s_chg && (sclk_i == cpol);
    sh_lead  = (role == ROLE_MASTER) ? cg_lead  : s_lead;
    sh_trail = (role == ROLE_MASTER) ? cg_trail : s_trail;
    sh_din   = (role == ROLE_MASTER) ? miso_i   : mosi_i;
    done_set = ((role == ROLE_MASTER) && cg_finish) ||
               ((role == ROLE_SEL) && sh_done) || fault;
    done_clr = wr_stat && bus_wdata[B_DONE];
    coll_set = wr_data && busy;
    coll_clr = wr_stat && bus_wdata[B_COLL];
  end

  spi_dr_clkgen #(.DW(DW), .MAX_HALF(MAX_HALF)) u_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (cg_start),
    .abort  (cg_abort),
    .rate   (rate),
    .busy   (cg_busy),
    .phase  (cg_phase),
    .lead   (cg_lead),
    .trail  (cg_trail),
    .finish (cg_finish)
  );

  spi_dr_shifter #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (sh_clear),
    .load      (sh_load),
    .load_val  (bus_wdata),
    .lead      (sh_lead),
    .trail     (sh_trail),
    .cpha      (cpha),
    .din       (sh_din),
    .sh        (sh),
    .mid       (sh_mid),
    .byte_done (sh_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      done_q      <= 1'b0;
      coll_q      <= 1'b0;
      sclk_prev_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[7:0];
      if (fault)   ctrl_q[B_MSTR] <= 1'b0;
      done_q      <= done_set || (done_q && !done_clr);
      coll_q      <= coll_set || (coll_q && !coll_clr);
      sclk_prev_q <= sclk_i;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = DW'(ctrl_q);
      A_STAT:  bus_rdata = DW'({done_q, coll_q, 6'b0});
      A_DATA:  bus_rdata = sh;
      default: bus_rdata = '0;
    endcase
    irq    = done_q && ctrl_q[B_IE] && gie;
    sclk_o = cpol ^ cg_phase;
    mosi_o = sh[DW-1];
    miso_o = sh[DW-1];
  end

  assert_fault_demotes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!ctrl_q[B_MSTR] && done_q && !cg_busy));
  assert_coll_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy) |=> coll_q);
  assert_w1c_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[B_DONE] && !done_set) |=> !done_q);
  assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[B_EN] |-> !(sclk_oe || mosi_oe || miso_oe || cg_busy));
  assert_desel_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (role == ROLE_DESEL) |=> !sh_mid);

endmodule

// File: tb/tb_spi_dual_role.sv
module tb_spi_dual_role;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       gie = 1'b0;
  logic       irq;
  logic       sclk_i = 1'b0, mosi_i = 1'b0, miso_i, ss_n_i = 1'b1;
  logic       sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // bench-side slave configuration (written by tasks)
  logic       bs_on = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [7:0] cfg_rx = 8'h00;
  // bench-side slave state (owned by its always block)
  logic       bs_prev, bs_mprev, bs_lead;
  logic [7:0] bs_sh, bs_cap;
  int         bs_n, bs_e, bs_t0, bs_t1;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_dual_role dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie), .irq(irq),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
  );

  always @(negedge clk) begin
    if (!bs_on) begin
      bs_sh = cfg_rx; bs_cap = 8'h00; bs_n = 0; bs_e = 0; bs_t0 = 0; bs_t1 = 0;
      miso_i = 1'b0;
    end else begin
      if (sclk_o != bs_prev) begin
        bs_lead = (sclk_o != cfg_cpol);
        if (bs_e == 0) bs_t0 = cyc;
        if (bs_e == 1) bs_t1 = cyc;
        bs_e = bs_e + 1;
        if (cfg_cpha ? !bs_lead : bs_lead) begin
          bs_cap = {bs_cap[6:0], bs_mprev};
          bs_n = bs_n + 1;
        end else if (cfg_cpha ? (bs_n >= 1) : (bs_n < 8)) begin
          bs_sh = {bs_sh[6:0], 1'b0};
        end
      end
      miso_i = bs_sh[7];
    end
    bs_prev  = sclk_o;
    bs_mprev = mosi_o;
  end

  function automatic logic [7:0] mkctrl(input logic ie, input logic [1:0] rate,
      input logic cpha, input logic cpol, input logic ssign, input logic mstr,
      input logic en);
    return {ie, rate, cpha, cpol, ssign, mstr, en};
  endfunction

  function automatic int exp_half(input logic [1:0] rate);
    return (rate == 2'd3) ? 64 : (2 << (2 * rate));
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_done(output logic ok);
    logic [7:0] s;
    ok = 1'b0;
    for (int i = 0; i < 4000 && !ok; i++) begin
      rd(2'd1, s);
      ok = s[7];
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1", "ctrl after reset", v, 8'h00);
    rd(2'd1, v); chk("R1", "status after reset", v, 8'h00);
    rd(2'd2, v); chk("R1", "data after reset", v, 8'h00);
    chk("R1", "oe after reset", {sclk_oe, mosi_oe, miso_oe}, 3'b000);
    chk("R1", "irq after reset", irq, 1'b0);
  endtask

  task automatic t_master(input logic [1:0] rate, input logic cpol, input logic cpha,
                          input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] v; logic ok;
    ss_n_i = 1'b1;
    wr(2'd0, mkctrl(1'b0, rate, cpha, cpol, 1'b0, 1'b1, 1'b1));
    wr(2'd1, 8'hC0);
    @(negedge clk); #1; cfg_cpol = cpol; cfg_cpha = cpha; cfg_rx = rx; bs_on = 1'b0;
    @(negedge clk); #1; bs_on = 1'b1;
    chk("R11", "idle sclk level", sclk_o, cpol);
    wr(2'd2, tx);
    chk("R12", "master pin enables", {sclk_oe, mosi_oe, miso_oe}, 3'b110);
    wait_done(ok);
    chk("R2", "master completion flag", ok, 1'b1);
    rd(2'd2, v);
    chk("R2", "master received byte", v, rx);
    chk("R2", "master sent byte MSB first", bs_cap, tx);
    chk("R2", "clock edge count", bs_e, 16);
    chk("R6", "half period", bs_t1 - bs_t0, exp_half(rate));
    chk("R11", "sclk back at idle", sclk_o, cpol);
    @(negedge clk); #1; bs_on = 1'b0;
  endtask

  task automatic t_collision();
    logic [7:0] v; logic ok;
    ss_n_i = 1'b1;
    wr(2'd0, mkctrl(1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    wr(2'd1, 8'hC0);
    @(negedge clk); #1; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_rx = 8'h96;
    @(negedge clk); #1; bs_on = 1'b1;
    wr(2'd2, 8'hA5);
    repeat (40) @(negedge clk);
    wr(2'd2, 8'h3C);
    rd(2'd1, v); chk("R4", "collision flag", v[6], 1'b1);
    wait_done(ok);
    rd(2'd2, v); chk("R4", "received byte kept", v, 8'h96);
    chk("R4", "sent byte kept", bs_cap, 8'hA5);
    @(negedge clk); #1; bs_on = 1'b0;
    // R3: write-1-to-clear on both flags
    rd(2'd1, v); chk("R3", "both flags set", v, 8'hC0);
    wr(2'd1, 8'h00); rd(2'd1, v); chk("R3", "writing 0 keeps flags", v, 8'hC0);
    wr(2'd1, 8'h40); rd(2'd1, v); chk("R3", "clear collision only", v, 8'h80);
    wr(2'd1, 8'h80); rd(2'd1, v); chk("R3", "clear completion", v, 8'h00);
  endtask

  task automatic t_slave(input logic cpol, input logic cpha,
                         input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] v; logic [7:0] got;
    got = 8'h00;
    ss_n_i = 1'b1; sclk_i = cpol; mosi_i = 1'b0;
    wr(2'd0, mkctrl(1'b0, 2'd0, cpha, cpol, 1'b0, 1'b0, 1'b1));
    wr(2'd1, 8'hC0);
    wr(2'd2, tx);
    @(negedge clk); ss_n_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8", "selected slave drives miso", {sclk_oe, mosi_oe, miso_oe}, 3'b001);
    for (int i = 0; i < 8; i++) begin
      if (!cpha) begin
        mosi_i = rx[7-i];
        repeat (2) @(negedge clk);
        got = {got[6:0], miso_o};
        sclk_i = ~cpol;
        repeat (4) @(negedge clk);
        sclk_i = cpol;
        repeat (4) @(negedge clk);
      end else begin
        sclk_i = ~cpol; mosi_i = rx[7-i];
        repeat (4) @(negedge clk);
        got = {got[6:0], miso_o};
        sclk_i = cpol;
        repeat (4) @(negedge clk);
      end
    end
    rd(2'd1, v); chk("R8", "slave completion flag", v[7], 1'b1);
    rd(2'd2, v); chk("R8", "slave received byte", v, rx);
    chk("R8", "slave sent byte (R11 phase)", got, tx);
    @(negedge clk); ss_n_i = 1'b1;
  endtask

  task automatic t_desel();
    logic [7:0] v;
    ss_n_i = 1'b1; sclk_i = 1'b0; mosi_i = 1'b1;
    wr(2'd0, mkctrl(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    wr(2'd1, 8'hC0);
    wr(2'd2, 8'h5A);
    for (int i = 0; i < 16; i++) begin
      sclk_i = ~sclk_i;
      repeat (3) @(negedge clk);
    end
    chk("R9", "deselected miso released", miso_oe, 1'b0);
    rd(2'd2, v); chk("R9", "deselected data unchanged", v, 8'h5A);
    rd(2'd1, v); chk("R9", "deselected flags unchanged", v, 8'h00);
  endtask

  task automatic t_fault();
    logic [7:0] v;
    ss_n_i = 1'b1;
    wr(2'd0, mkctrl(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    wr(2'd1, 8'hC0);
    wr(2'd2, 8'hE7);
    repeat (100) @(negedge clk);
    ss_n_i = 1'b0;
    @(negedge clk);
    chk("R5", "sclk released on fault", sclk_oe, 1'b0);
    rd(2'd0, v); chk("R5", "master bit cleared", v[1], 1'b0);
    rd(2'd1, v); chk("R5", "mode change flagged", v[7], 1'b1);
    chk("R5", "now an active slave", miso_oe, 1'b1);
    @(negedge clk); ss_n_i = 1'b1;
    wr(2'd1, 8'hC0);
  endtask

  task automatic t_off();
    logic [7:0] v;
    wr(2'd0, mkctrl(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    wr(2'd1, 8'hC0);
    ss_n_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7", "disabled pins released", {sclk_oe, mosi_oe, miso_oe}, 3'b000);
    rd(2'd0, v); chk("R7", "no fault while disabled", v, 8'h02);
    wr(2'd2, 8'h77);
    repeat (300) @(negedge clk);
    rd(2'd1, v); chk("R7", "no transfer while disabled", v, 8'h00);
    rd(2'd2, v); chk("R7", "data loaded untouched", v, 8'h77);
    ss_n_i = 1'b1;
  endtask

  task automatic t_irq();
    ss_n_i = 1'b1; gie = 1'b0;
    wr(2'd0, mkctrl(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    wr(2'd1, 8'hC0);
    @(negedge clk); ss_n_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10", "irq blocked by global enable", irq, 1'b0);
    gie = 1'b1; #1;
    chk("R10", "irq with both enables", irq, 1'b1);
    wr(2'd0, mkctrl(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    chk("R10", "irq blocked by local enable", irq, 1'b0);
    wr(2'd0, mkctrl(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    chk("R10", "irq returns", irq, 1'b1);
    wr(2'd1, 8'h80);
    chk("R10", "irq gone after clear", irq, 1'b0);
    ss_n_i = 1'b1; gie = 1'b0;
  endtask

  initial begin
    logic wd;
    wd = 1'b0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_master(2'd0, 1'b0, 1'b0, 8'hA5, 8'h3C);
        t_master(2'd1, 1'b1, 1'b0, 8'h81, 8'h7E);
        t_master(2'd2, 1'b0, 1'b1, 8'h5A, 8'hC3);
        t_master(2'd3, 1'b1, 1'b1, 8'hFF, 8'h00);
        t_collision();
        t_slave(1'b0, 1'b0, 8'hB4, 8'h2D);
        t_slave(1'b1, 1'b1, 8'h0F, 8'hF0);
        t_slave(1'b0, 1'b1, 8'h69, 8'h96);
        t_desel();
        t_fault();
        t_off();
        t_irq();
      end
      begin
        repeat (WD_LIMIT) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule